// File: doc/BRIEF.md
# Gradient-Descent Channel Estimate Updater

This block refines a matrix of complex channel estimates for a multiuser receiver without inverting any matrix. The estimate matrix has M = 2K rows (K users) and N columns (chips); every entry holds a real part and an imaginary part, each an 8-bit signed integer. One update pass works through the columns. For each column it multiplies the real auto-correlation matrix by that column of the estimate and takes away the matching column of the cross-correlation matrix. The resulting error is divided by a power of two with an arithmetic right shift, which acts as the step size. That scaled error is then subtracted from the old column, and the result is clamped to the 8-bit range.

The block keeps the estimate in its own register array. A host port loads the array before a pass and reads it back afterwards. Both correlation matrices live outside the block and are read through memory-style ports. The auto-correlation port returns a whole column of M entries on each read. This feeds M parallel multipliers, one per row, and each one accumulates a dot product as the column index steps once per cycle. One pass therefore issues M·N reads, i.e. 2K·N cycles, rather than the 4K²N cycles a single multiplier would need. Each column is written back one cycle after its last product, overlapped with the first product of the next column.

Top module: `gd_chan_update`

## Requirements
- R1: After reset `done` is low and no pass is running; a pass begins only when `start` is high while the block is idle.
- R2: For column n and row i, with R the auto-correlation (R[i][j] is bits [i*RW +: RW] of `rbb_col` when `rbb_addr` was j) and C the cross-correlation, the block computes e = sum over j of R[i][j]*A[j][n] - C[i][n]. The new entry is A[i][n] - (e >>> s), where >>> is an arithmetic shift and s is the shift amount. The real and imaginary parts are handled independently, with the same R.
- R3: Every updated part is saturated to the range -128..127.
- R4: All rows of a column are computed from the estimate values held before the pass; no row sees a value already updated in the same pass.
- R5: `done` is a one-cycle pulse that rises in the cycle M·N+2 clock edges after the edge that accepted `start`; the updated estimate is readable from that cycle on.
- R6: The shift amount is taken from `shift` at the edge that accepts `start`; changes to `shift` during a pass have no effect on its result.
- R7: `start` asserted while a pass is in progress is ignored; it neither restarts the pass nor adds a second one.
- R8: Host word format is real part in bits [7:0] and imaginary part in bits [15:8], at address row*N + col. `a_rdata` shows the word at the `a_addr` of the previous cycle. Host writes made while a pass is in progress are ignored.
- R9: During a pass `rbb_addr` counts 0..M-1 once per cycle and repeats for each column, M·N cycles in total. `rbr_addr` gives the column whose cross-correlation is needed; `rbr_col` is expected to return, one cycle later, entry i real part at bits [i*2*CW +: CW] and imaginary part at bits [i*2*CW+CW +: CW].
- R10: A shift of 0 subtracts the full error and a shift of 15 subtracts only the error's top bits, both with the arithmetic (floor) rounding of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a pass when idle |
| shift | input | 4 | Step-size shift amount, latched at start |
| done | output | 1 | One-cycle pulse at pass completion |
| rbb_addr | output | clog2(2K) | Auto-correlation column address |
| rbb_col | input | 2K*RW | Auto-correlation column, one cycle after address |
| rbr_addr | output | clog2(N) (min 1) | Cross-correlation column address |
| rbr_col | input | 2K*2*CW | Cross-correlation column, complex, one cycle after address |
| a_we | input | 1 | Host write enable for the estimate array |
| a_addr | input | clog2(2K*N) | Host address, row*N + col |
| a_wdata | input | 16 | Host write word {imag, real} |
| a_rdata | output | 16 | Host read word, one cycle latency |

## Verification
The update is tried first with an identity auto-correlation and zero cross-correlation, which isolates the shift-and-subtract path from the accumulation. Random signed correlation matrices with non-zero off-diagonal terms follow; these tell a column-wide (Jacobi) update apart from one that feeds freshly written rows back in, and they catch sign errors in the products. A zero auto-correlation with cross-correlation terms of large magnitude and either sign drives both saturation limits. Shifts of 0 and 15 exercise the ends of the step range. Separate passes change `shift`, pulse `start` and issue a host write in mid-pass, and show at the read port that none of these reaches the result.

// File: rtl/gd_chan_update.sv
module gd_chan_update #(
  parameter int K  = 32,
  parameter int N  = 32,
  parameter int RW = 8,
  parameter int CW = 16,
  localparam int M   = 2 * K,
  localparam int MW  = $clog2(M),
  localparam int NW  = (N > 1) ? $clog2(N) : 1,
  localparam int AAW = $clog2(M * N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          shift,
  output logic                done,
  output logic [MW-1:0]       rbb_addr,
  input  logic [M*RW-1:0]     rbb_col,
  output logic [NW-1:0]       rbr_addr,
  input  logic [2*M*CW-1:0]   rbr_col,
  input  logic                a_we,
  input  logic [AAW-1:0]      a_addr,
  input  logic [15:0]         a_wdata,
  output logic [15:0]         a_rdata
);
  localparam int DEP = M * N;
  localparam int PW  = RW + 8;
  localparam int AW  = PW + MW + 1;
  localparam int EW  = ((AW > CW) ? AW : CW) + 1;

  logic signed [7:0] are_q [DEP];
  logic signed [7:0] aim_q [DEP];

  logic          busy_q, v_d, wb_q, done_q;
  logic [MW-1:0] j_q, j_d;
  logic [NW-1:0] n_q, col_d, wbcol_q;
  logic [3:0]    sh_q;
  logic          active;

  assign active   = busy_q | v_d | wb_q;
  assign rbb_addr = j_q;
  assign rbr_addr = col_d;
  assign done     = done_q;

  function automatic logic signed [7:0] sat8(input logic signed [EW:0] v);
    if (v > (EW+1)'(127))  return 8'sd127;
    if (v < (EW+1)'(-128)) return -8'sd128;
    return v[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      j_q     <= '0;
      n_q     <= '0;
      sh_q    <= '0;
      v_d     <= 1'b0;
      j_d     <= '0;
      col_d   <= '0;
      wb_q    <= 1'b0;
      wbcol_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (!active && start) begin
        busy_q <= 1'b1;
        j_q    <= '0;
        n_q    <= '0;
        sh_q   <= shift;
      end else if (busy_q) begin
        if (j_q == MW'(M - 1)) begin
          j_q <= '0;
          if (n_q == NW'(N - 1)) busy_q <= 1'b0;
          else                   n_q    <= n_q + 1'b1;
        end else begin
          j_q <= j_q + 1'b1;
        end
      end
      v_d     <= busy_q;
      j_d     <= j_q;
      col_d   <= n_q;
      wb_q    <= v_d && (j_d == MW'(M - 1));
      wbcol_q <= col_d;
      done_q  <= wb_q && (wbcol_q == NW'(N - 1));
    end
  end

  logic [AAW-1:0]    rd_idx;
  logic signed [7:0] a_re_sel, a_im_sel;
  assign rd_idx   = AAW'(j_d) * AAW'(N) + AAW'(col_d);
  assign a_re_sel = are_q[rd_idx];
  assign a_im_sel = aim_q[rd_idx];

  logic signed [7:0] nre [M];
  logic signed [7:0] nim [M];

  for (genvar i = 0; i < M; i++) begin : row
    logic signed [RW-1:0] r_i;
    logic signed [PW-1:0] p_re, p_im;
    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [CW-1:0] c_re, c_im;
    logic signed [EW-1:0] err_re, err_im, stp_re, stp_im;
    logic [AAW-1:0]       old_idx;

    assign r_i  = rbb_col[i*RW +: RW];
    assign p_re = PW'(r_i) * PW'(a_re_sel);
    assign p_im = PW'(r_i) * PW'(a_im_sel);

    always_ff @(posedge clk) begin
      if (v_d) begin
        if (j_d == '0) begin
          acc_re <= AW'(p_re);
          acc_im <= AW'(p_im);
        end else begin
          acc_re <= acc_re + AW'(p_re);
          acc_im <= acc_im + AW'(p_im);
        end
      end
    end

    assign c_re    = rbr_col[i*2*CW +: CW];
    assign c_im    = rbr_col[i*2*CW+CW +: CW];
    assign err_re  = EW'(acc_re) - EW'(c_re);
    assign err_im  = EW'(acc_im) - EW'(c_im);
    assign stp_re  = err_re >>> sh_q;
    assign stp_im  = err_im >>> sh_q;
    assign old_idx = AAW'(i * N) + AAW'(wbcol_q);
    assign nre[i]  = sat8((EW+1)'(are_q[old_idx]) - (EW+1)'(stp_re));
    assign nim[i]  = sat8((EW+1)'(aim_q[old_idx]) - (EW+1)'(stp_im));
  end

  always_ff @(posedge clk) begin
    a_rdata <= {aim_q[a_addr], are_q[a_addr]};
    if (wb_q) begin
      for (int i = 0; i < M; i++) begin
        are_q[AAW'(i * N) + AAW'(wbcol_q)] <= nre[i];
        aim_q[AAW'(i * N) + AAW'(wbcol_q)] <= nim[i];
      end
    end else if (a_we && !active) begin
      are_q[a_addr] <= a_wdata[7:0];
      aim_q[a_addr] <= a_wdata[15:8];
    end
  end
endmodule

module gd_chan_update_chk #(
  parameter int MW = 1,
  parameter int NW = 1,
  parameter int M  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy_q,
  input logic          v_d,
  input logic [MW-1:0] rbb_addr,
  input logic [MW-1:0] j_d,
  input logic [NW-1:0] rbr_addr,
  input logic [3:0]    sh_q
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy_q && !v_d));

  // R9
  rbb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rbb_addr != MW'(M - 1)) |=> (rbb_addr == MW'($past(rbb_addr) + 1'b1)));

  // R9
  rbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && j_d != '0) |-> $stable(rbr_addr));

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sh_q));
endmodule

bind gd_chan_update gd_chan_update_chk #(.MW(MW), .NW(NW), .M(M)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .busy_q(busy_q), .v_d(v_d),
  .rbb_addr(rbb_addr), .j_d(j_d), .rbr_addr(rbr_addr), .sh_q(sh_q)
);

// File: tb/gd_chan_update_test.sv
`timescale 1ns/1ps
module gd_chan_update_test;
  localparam int K = 2, N = 3, M = 4, RW = 8, CW = 16;
  localparam int DEP = M * N, AAW = 4, MW = 2, NW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n, start, done, a_we;
  logic [3:0]          shift;
  logic [MW-1:0]       rbb_addr;
  logic [M*RW-1:0]     rbb_col;
  logic [NW-1:0]       rbr_addr;
  logic [2*M*CW-1:0]   rbr_col;
  logic [AAW-1:0]      a_addr;
  logic [15:0]         a_wdata, a_rdata;

  gd_chan_update #(.K(K), .N(N), .RW(RW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .shift(shift), .done(done),
    .rbb_addr(rbb_addr), .rbb_col(rbb_col), .rbr_addr(rbr_addr), .rbr_col(rbr_col),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata)
  );

  logic signed [7:0]  rm  [M][M];
  logic signed [15:0] cre [M][N];
  logic signed [15:0] cim [M][N];
  int are [M][N];
  int aim [M][N];
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    for (int i = 0; i < M; i++) begin
      rbb_col[i*RW +: RW]       <= rm[i][rbb_addr];
      rbr_col[i*2*CW +: CW]     <= cre[i][rbr_addr];
      rbr_col[i*2*CW+CW +: CW]  <= cim[i][rbr_addr];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int s8(input int v);
    return ((v + 128) & 255) - 128;
  endfunction

  task automatic host_write(input int addr, input logic [15:0] w);
    a_addr = AAW'(addr); a_wdata = w; a_we = 1'b1;
    @(posedge clk); @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < M; r++)
      for (int c = 0; c < N; c++)
        host_write(r * N + c, {8'(aim[r][c]), 8'(are[r][c])});
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < M; r++)
      for (int c = 0; c < N; c++) begin
        a_addr = AAW'(r * N + c);
        @(posedge clk); @(negedge clk);
        chk({tag, " real"}, int'($signed(a_rdata[7:0])),  are[r][c]);
        chk({tag, " imag"}, int'($signed(a_rdata[15:8])), aim[r][c]);
      end
  endtask

  task automatic model_pass(input int sh);
    int nr [M][N];
    int ni [M][N];
    for (int c = 0; c < N; c++)
      for (int i = 0; i < M; i++) begin
        int er = 0, ei = 0;
        for (int j = 0; j < M; j++) begin
          er += int'(rm[i][j]) * are[j][c];
          ei += int'(rm[i][j]) * aim[j][c];
        end
        er -= int'(cre[i][c]);
        ei -= int'(cim[i][c]);
        nr[i][c] = sat(are[i][c] - (er >>> sh));
        ni[i][c] = sat(aim[i][c] - (ei >>> sh));
      end
    are = nr;
    aim = ni;
  endtask

  // disturb: 0 none, 1 change shift, 2 extra start, 3 host write
  task automatic run_pass(input int sh, input int disturb);
    model_pass(sh);
    shift = 4'(sh); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= M * N + 3; c++) begin
      chk("R5 done timing", int'(done), int'(c == M * N + 2));
      if (c < M * N) chk("R9 rbb_addr sequence", int'(rbb_addr), c % M);
      if (c == 2) begin
        if (disturb == 1) shift = 4'(sh ^ 5);
        if (disturb == 2) start = 1'b1;
        if (disturb == 3) begin a_addr = '0; a_wdata = 16'h3b3b; a_we = 1'b1; end
      end
      if (c == 3) begin start = 1'b0; a_we = 1'b0; end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic rand_fill(input int rmax, input int cmax, input int amax);
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) rm[i][j] = 8'($urandom_range(2 * rmax) - rmax);
      for (int c = 0; c < N; c++) begin
        cre[i][c] = 16'($urandom_range(2 * cmax) - cmax);
        cim[i][c] = 16'($urandom_range(2 * cmax) - cmax);
        are[i][c] = s8($urandom_range(2 * amax) - amax);
        aim[i][c] = s8($urandom_range(2 * amax) - amax);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; shift = '0; a_we = 1'b0; a_addr = '0; a_wdata = '0;
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) rm[i][j] = '0;
      for (int c = 0; c < N; c++) begin cre[i][c] = '0; cim[i][c] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done low after reset", int'(done), 0);

    // R2 identity auto-correlation, zero cross-correlation, shift 1
    rand_fill(0, 0, 120);
    for (int i = 0; i < M; i++) rm[i][i] = 8'sd1;
    load_all();
    read_all("R8 host load readback");
    run_pass(1, 0);
    read_all("R2 identity pass");

    // R2 R4 random matrices with off-diagonal terms
    rand_fill(7, 300, 40);
    load_all();
    run_pass(3, 0);
    read_all("R2 R4 random pass");

    // R6 shift input changed mid-pass
    rand_fill(5, 200, 30);
    load_all();
    run_pass(2, 1);
    read_all("R6 latched shift");

    // R7 start pulsed mid-pass
    rand_fill(9, 500, 60);
    load_all();
    run_pass(4, 2);
    read_all("R7 start ignored");
    chk("R7 no second done", int'(done), 0);

    // R8 host write mid-pass is ignored
    rand_fill(6, 250, 50);
    load_all();
    run_pass(5, 3);
    read_all("R8 write ignored");

    // R3 saturation at both limits, R10 shift 0
    rand_fill(0, 0, 100);
    for (int i = 0; i < M; i++)
      for (int c = 0; c < N; c++) begin
        cre[i][c] = (i % 2 == 0) ? -16'sd20000 : 16'sd20000;
        cim[i][c] = (c % 2 == 0) ? 16'sd20000 : -16'sd20000;
      end
    load_all();
    run_pass(0, 0);
    read_all("R3 R10 saturation shift 0");

    // R10 shift 15 with large operands
    rand_fill(127, 30000, 127);
    load_all();
    run_pass(15, 0);
    read_all("R10 shift 15");

    // R10 shift 0 without saturation pressure
    rand_fill(1, 20, 10);
    load_all();
    run_pass(0, 0);
    read_all("R10 shift 0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule